// File: doc/BRIEF.md
# SPI-Programmable Direct Digital Synthesizer

This block is a numerically controlled oscillator. It is configured one 16-bit word at a time through a serial slave port. Two 28-bit tuning words and two 12-bit phase offsets are held inside, and a 28-bit phase accumulator adds the selected tuning word on every master clock. The output frequency is therefore f_clk × F / 2^28. For example, a 16 MHz clock with F = 16777216 gives 1 MHz.

The top 12 bits of the accumulator are offset by the selected phase word. The upper 10 bits of that sum address a quarter-wave sine table, or a triangle shaper, which produces a 10-bit amplitude code. A one-bit sign output can follow the accumulator MSB, the MSB divided by two, or a comparison of the amplitude against mid-scale.

The serial pins are oversampled in the master clock domain, so a frame becomes a single-cycle write inside that domain. A 28-bit tuning word is loaded as two frames. It changes as one value, and only after its second half has arrived.

Top module: `dds_core`

## Requirements
- R1: The serial port uses mode 2. SCLK idles high, MOSI is sampled on each falling SCLK edge while CS_n is low, and bits arrive MSB first. A frame is committed when CS_n rises, and only if exactly 16 bits were clocked in. Any other count is discarded.
- R2: Word address decode: bits[15:14]=00 is a control word; 01 writes tuning word 0 and 10 writes tuning word 1, with a 14-bit payload in bits[13:0]; bits[15:13]=110 writes phase word 0 and 111 writes phase word 1, with a 12-bit payload in bits[11:0].
- R3: When control bit 13 is set, tuning writes pair up. The first write supplies bits[13:0], and the second write supplies bits[27:14] and commits the full 28-bit value to the register addressed by the second write. Before that commit the register keeps its old value. Any control write restarts the pairing.
- R4: When control bit 13 is clear, a tuning write replaces bits[13:0] of the addressed register and leaves bits[27:14] unchanged.
- R5: Each master clock the accumulator adds tuning word 1 if control bit 11 is set, otherwise tuning word 0.
- R6: The phase word chosen by control bit 10 (1 = phase word 1) is added modulo 2^12 to accumulator bits[27:16]. Bits[11:2] of the sum form the 10-bit lookup phase, and sum bits[1:0] have no effect.
- R7: Sine mode (control bit 1 clear): for lookup phase q, let p = q[8:0] and m = floor(511·16·p·(512−p) / (5·512² − 4·p·(512−p))). The amplitude is 512+m when q[9]=0 and 511−m when q[9]=1.
- R8: Triangle mode (control bit 1 set): the amplitude is 2·q[8:0] when q[9]=0 and 1023 − 2·q[8:0] when q[9]=1.
- R9: Control bit 8 holds the accumulator at zero, the amplitude at 512 and the sign output low. Writes to the phase and tuning registers are still accepted while it is set. After rst_n, control reads as 0x0100 and all other registers are zero.
- R10: Sign output: low when control bit 5 is clear. With bit 5 set and bit 4 set, it is high when the amplitude is at least 512. With bit 5 set and bit 4 clear, it follows the accumulator MSB if bit 3 is set, or a divide-by-two of that MSB (toggling on each MSB rising edge) if bit 3 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in, MSB first |
| amp_out | output | 10 | Amplitude code, mid-scale 512 |
| sign_out | output | 1 | Selected sign / square output |

## Verification
The assertions check several properties on every cycle. A frame commit is a single-cycle pulse. A tuning register changes only when a pairing completes while paired loading is on. A single write never disturbs the high tuning half when paired loading is off. A phase register changes only after its own address. Holding the accumulator zeroes the accumulator and the sign and parks the amplitude at mid-scale. The divided sign rises only after an MSB rising edge, and the sign stays low while disabled. Only the bench's scenarios can show the exact sine and triangle codes at chosen phases, and that the selected tuning word sets the output rate (counted as sign edges over a fixed window). They also show that short frames are dropped and that a control write restarts a half-finished pair.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int ACC_BITS  = 28;
  localparam int PHASE_BITS = 12;
  localparam int AMP_BITS  = 10;
  localparam int LUT_BITS  = 10;
  localparam int FRAME_BITS = 16;

  // Rational sine approximation for one quarter wave, index i in [0, H/2]
  function automatic int quarter_mag(input int i, input int amp_w, input int lut_w);
    longint h, a, x;
    h = longint'(1) << (lut_w - 1);
    a = (longint'(1) << (amp_w - 1)) - 1;
    x = longint'(i) * (h - longint'(i));
    return int'((a * 16 * x) / (5 * h * h - 4 * x));
  endfunction
endpackage

// File: rtl/dds_spi_rx.sv
module dds_spi_rx #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  output logic         word_valid,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 2);

  logic [SYNC-1:0] sy_sclk, sy_cs, sy_mosi;
  logic            sclk_d, cs_d;
  logic [CW-1:0]   bit_cnt;
  logic [W-1:0]    shreg;

  wire sclk_s    = sy_sclk[SYNC-1];
  wire cs_s      = sy_cs[SYNC-1];
  wire sclk_fall = sclk_d & ~sclk_s;
  wire cs_rise   = ~cs_d & cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_sclk    <= '1;
      sy_cs      <= '1;
      sy_mosi    <= '0;
      sclk_d     <= 1'b1;
      cs_d       <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      sy_sclk    <= {sy_sclk[SYNC-2:0], sclk};
      sy_cs      <= {sy_cs[SYNC-2:0], cs_n};
      sy_mosi    <= {sy_mosi[SYNC-2:0], mosi};
      sclk_d     <= sclk_s;
      cs_d       <= cs_s;
      word_valid <= 1'b0;
      if (cs_rise) begin
        word_valid <= (bit_cnt == CW'(W));
        word       <= shreg;
        bit_cnt    <= '0;
      end else if (!cs_s && sclk_fall) begin
        shreg <= {shreg[W-2:0], sy_mosi[SYNC-1]};
        if (bit_cnt <= CW'(W)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R1: a committed frame is a single-cycle event
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

// File: rtl/dds_regs.sv
module dds_regs #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int FW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_valid,
  input  logic [FW-1:0]    word,
  output logic [ACC_W-1:0] step,
  output logic [PH_W-1:0]  offset,
  output logic             hold,
  output logic             tri_mode,
  output logic             sign_en,
  output logic             sign_cmp,
  output logic             sign_msb
);
  localparam int PAY_W = ACC_W / 2;
  localparam int NREG  = 2;

  typedef struct packed {
    logic pair_load;
    logic fsel;
    logic psel;
    logic hold;
    logic sign_en;
    logic sign_cmp;
    logic sign_msb;
    logic tri_mode;
  } ctl_t;

  ctl_t             ctl_q;
  logic [ACC_W-1:0] freq_q [NREG];
  logic [PH_W-1:0]  ph_q   [NREG];
  logic [PAY_W-1:0] low_hold;
  logic             half_q;

  wire [PAY_W-1:0] pay    = word[PAY_W-1:0];
  wire             is_ctl = word_valid && (word[FW-1:FW-2] == 2'b00);
  wire             is_frq = word_valid && (word[FW-1] ^ word[FW-2]);
  wire             is_ph  = word_valid && (word[FW-1:FW-3] inside {3'b110, 3'b111});
  wire             f_idx  = word[FW-1];
  wire             p_idx  = word[FW-3];
  wire unused_word_bits   = ^{word[12], word[9], word[7:6], word[2], word[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      ctl_q.hold <= 1'b1;
    end else if (is_ctl) begin
      ctl_q.pair_load <= word[13];
      ctl_q.fsel      <= word[11];
      ctl_q.psel      <= word[10];
      ctl_q.hold      <= word[8];
      ctl_q.sign_en   <= word[5];
      ctl_q.sign_cmp  <= word[4];
      ctl_q.sign_msb  <= word[3];
      ctl_q.tri_mode  <= word[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      low_hold <= '0;
    end else if (is_ctl) begin
      half_q <= 1'b0;
    end else if (is_frq && ctl_q.pair_load) begin
      if (!half_q) low_hold <= pay;
      half_q <= ~half_q;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_q[g] <= '0;
      end else if (is_frq && (f_idx == 1'(g))) begin
        if (!ctl_q.pair_load) freq_q[g][PAY_W-1:0] <= pay;
        else if (half_q)      freq_q[g] <= {pay, low_hold};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ph_q[g] <= '0;
      else if (is_ph && (p_idx == 1'(g)))   ph_q[g] <= word[PH_W-1:0];
    end

    // R3: under paired loading a tuning word moves only on the second frame
    a_r3_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.pair_load && !$stable(freq_q[g])) |-> $past(half_q));
    // R4: single writes never disturb the high half
    a_r4_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.pair_load && !$stable(freq_q[g])) |->
        (freq_q[g][ACC_W-1:PAY_W] == $past(freq_q[g][ACC_W-1:PAY_W])));
    // R2: a phase word changes only after its own address arrived
    a_r2_phase_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ph_q[g]) |-> $past(word_valid && word[FW-1:FW-2] == 2'b11 && word[FW-3] == 1'(g)));
  end

  assign step     = freq_q[ctl_q.fsel];
  assign offset   = ph_q[ctl_q.psel];
  assign hold     = ctl_q.hold;
  assign tri_mode = ctl_q.tri_mode;
  assign sign_en  = ctl_q.sign_en;
  assign sign_cmp = ctl_q.sign_cmp;
  assign sign_msb = ctl_q.sign_msb;
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath #(
  parameter int ACC_W  = 28,
  parameter int PH_W   = 12,
  parameter int AMP_W  = 10,
  parameter int LUT_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  input  logic [PH_W-1:0]  offset,
  input  logic             hold,
  input  logic             tri_mode,
  input  logic             sign_en,
  input  logic             sign_cmp,
  input  logic             sign_msb,
  output logic [AMP_W-1:0] amp,
  output logic             sign
);
  import dds_pkg::*;

  localparam int QW  = AMP_W - 1;
  localparam int QN  = (1 << (LUT_AW - 2)) + 1;
  localparam int PW  = LUT_AW - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  function automatic logic [AMP_W-1:0] fold_sine(input logic neg, input logic [QW-1:0] m);
    return neg ? (MID - 1'b1 - AMP_W'(m)) : (MID + AMP_W'(m));
  endfunction

  function automatic logic [AMP_W-1:0] tri_wave(input logic [LUT_AW-1:0] q);
    logic [LUT_AW-1:0] ramp;
    ramp = {q[LUT_AW-2:0], 1'b0};
    return AMP_W'(q[LUT_AW-1] ? ~ramp : ramp);
  endfunction

  logic [QW-1:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_qtab
    assign qtab[g] = QW'(quarter_mag(g, AMP_W, LUT_AW));
  end

  logic [ACC_W-1:0] acc_q;
  logic             msb_d, div2_q;
  logic [AMP_W-1:0] amp_q;
  logic             sign_q;

  wire [PH_W-1:0]   ph_sum   = acc_q[ACC_W-1 -: PH_W] + offset;
  wire [LUT_AW-1:0] lut_ph   = ph_sum[PH_W-1 -: LUT_AW];
  wire unused_ph_lsbs        = ^ph_sum[PH_W-LUT_AW-1:0];
  wire [PW-1:0]     p        = lut_ph[PW-1:0];
  wire [LUT_AW-1:0] mirror   = LUT_AW'(1 << PW) - {1'b0, p};
  wire [PW-1:0]     qidx     = p[PW-1] ? PW'(mirror) : p;
  wire              acc_msb  = acc_q[ACC_W-1];
  wire              msb_rise = acc_msb & ~msb_d;
  wire [AMP_W-1:0]  amp_next = tri_mode ? tri_wave(lut_ph) : fold_sine(lut_ph[LUT_AW-1], qtab[qidx]);
  wire              sign_next = !sign_en ? 1'b0 :
                                sign_cmp ? amp_next[AMP_W-1] :
                                sign_msb ? acc_msb : div2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      msb_d  <= 1'b0;
      div2_q <= 1'b0;
      amp_q  <= MID;
      sign_q <= 1'b0;
    end else if (hold) begin
      acc_q  <= '0;
      msb_d  <= 1'b0;
      div2_q <= 1'b0;
      amp_q  <= MID;
      sign_q <= 1'b0;
    end else begin
      acc_q  <= acc_q + step;
      msb_d  <= acc_msb;
      if (msb_rise) div2_q <= ~div2_q;
      amp_q  <= amp_next;
      sign_q <= sign_next;
    end
  end

  assign amp  = amp_q;
  assign sign = sign_q;

  // R9: holding parks the whole datapath
  a_r9_hold_park: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> (acc_q == '0 && amp_q == MID && !sign_q));
  // R10: the divided sign rises only after an MSB rising edge
  a_r10_div2_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div2_q) |-> $past(msb_rise));
  // R10: disabled sign output stays low
  a_r10_sign_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sign_en) |-> !sign_q);
endmodule

// File: rtl/dds_core.sv
module dds_core #(
  parameter int ACC_W  = dds_pkg::ACC_BITS,
  parameter int PH_W   = dds_pkg::PHASE_BITS,
  parameter int AMP_W  = dds_pkg::AMP_BITS,
  parameter int LUT_AW = dds_pkg::LUT_BITS,
  parameter int FW     = dds_pkg::FRAME_BITS,
  parameter int SYNC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic [AMP_W-1:0] amp_out,
  output logic             sign_out
);
  logic             word_valid;
  logic [FW-1:0]    word;
  logic [ACC_W-1:0] step;
  logic [PH_W-1:0]  offset;
  logic             hold, tri_mode, sign_en, sign_cmp, sign_msb;

  dds_spi_rx #(.W(FW), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .word_valid(word_valid), .word(word)
  );

  dds_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
    .step(step), .offset(offset), .hold(hold), .tri_mode(tri_mode),
    .sign_en(sign_en), .sign_cmp(sign_cmp), .sign_msb(sign_msb)
  );

  dds_datapath #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W), .LUT_AW(LUT_AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .step(step), .offset(offset), .hold(hold),
    .tri_mode(tri_mode), .sign_en(sign_en), .sign_cmp(sign_cmp), .sign_msb(sign_msb),
    .amp(amp_out), .sign(sign_out)
  );
endmodule

// File: tb/tb_dds_core.sv
module tb_dds_core;
  localparam int CLK_PERIOD = 10;
  localparam int HB         = 4;
  localparam int WINDOW     = 320;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b1;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic [9:0] amp_out;
  logic       sign_out;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_core dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .amp_out(amp_out), .sign_out(sign_out)
  );

  typedef struct packed {
    logic [15:0] ctl;
    logic [15:0] ph;
    logic [9:0]  amp;
    logic        sgn;
  } vec_t;

  // control 0x0030: sine, comparator sign; 0x0032: triangle, comparator sign
  localparam vec_t VEC [11] = '{
    '{16'h0030, 16'hC000, 10'd512,  1'b1},
    '{16'h0030, 16'hC400, 10'd1023, 1'b1},
    '{16'h0030, 16'hC800, 10'd511,  1'b0},
    '{16'h0030, 16'hCC00, 10'd0,    1'b0},
    '{16'h0030, 16'hC200, 10'd872,  1'b1},
    '{16'h0030, 16'hCA00, 10'd151,  1'b0},
    '{16'h0030, 16'hC403, 10'd1023, 1'b1},
    '{16'h0032, 16'hC000, 10'd0,    1'b0},
    '{16'h0032, 16'hC400, 10'd512,  1'b1},
    '{16'h0032, 16'hCC00, 10'd511,  1'b0},
    '{16'h0032, 16'hC200, 10'd256,  1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic spi_send(input logic [15:0] w, input int nbits);
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (HB) @(negedge clk);
    for (int i = 15; i > 15 - nbits; i--) begin
      spi_mosi = w[i];
      repeat (HB) @(negedge clk); spi_sclk = 1'b0;
      repeat (HB) @(negedge clk); spi_sclk = 1'b1;
    end
    repeat (HB) @(negedge clk); spi_cs_n = 1'b1;
    repeat (2*HB) @(negedge clk);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic count_edges(output int n);
    logic prev;
    n = 0;
    @(negedge clk); prev = sign_out;
    for (int i = 0; i < WINDOW; i++) begin
      @(negedge clk);
      if (sign_out && !prev) n++;
      prev = sign_out;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R9 reset amplitude", amp_out, 512);
    check("R9 reset sign", sign_out, 0);

    // R7 R8 R6 R10 R2: static phase points with zero tuning word
    for (int k = 0; k < 11; k++) begin
      spi_send(VEC[k].ctl, 16);
      spi_send(VEC[k].ph, 16);
      settle();
      check("R7/R8/R6 amplitude", amp_out, VEC[k].amp);
      check("R10 comparator sign", sign_out, VEC[k].sgn);
    end

    // R2 R6: phase word 1 only through its select
    spi_send(16'h0000, 16);
    spi_send(16'hC000, 16);
    spi_send(16'hE400, 16);
    settle();
    check("R6 psel clear uses phase 0", amp_out, 512);
    spi_send(16'h0400, 16);
    settle();
    check("R2 phase word 1 selected", amp_out, 1023);

    // R9: hold parks output, writes still land
    spi_send(16'h0500, 16);
    settle();
    check("R9 hold amplitude", amp_out, 512);
    spi_send(16'hEC00, 16);
    settle();
    check("R9 hold amplitude after write", amp_out, 512);
    spi_send(16'h0400, 16);
    settle();
    check("R9 write accepted during hold", amp_out, 0);

    // R1: 15-bit frame discarded
    spi_send(16'hE400, 15);
    settle();
    check("R1 short frame ignored", amp_out, 0);

    // R3 R5: paired loading of tuning word 0 = 2^24 (period 16)
    spi_send(16'hC000, 16);
    spi_send(16'hE000, 16);
    spi_send(16'h2028, 16);
    spi_send(16'h4000, 16);
    spi_send(16'h4400, 16);
    settle();
    count_edges(n);
    check("R5 rate of tuning word 0", n, 20);
    spi_send(16'h4000, 16);
    settle();
    count_edges(n);
    check("R3 first half not applied", n, 20);
    spi_send(16'h4800, 16);
    settle();
    count_edges(n);
    check("R3 pair committed", n, 40);

    // R3: control write restarts pairing
    spi_send(16'h4000, 16);
    spi_send(16'h2128, 16);
    spi_send(16'h4400, 16);
    spi_send(16'h4000, 16);
    spi_send(16'h2028, 16);
    count_edges(n);
    check("R3 control write restarts pair", n, 0);

    // R4: single write keeps the high half
    spi_send(16'h4000, 16);
    spi_send(16'h4400, 16);
    settle();
    count_edges(n);
    check("R5 rate restored", n, 20);
    spi_send(16'h0028, 16);
    spi_send(16'h4000, 16);
    settle();
    count_edges(n);
    check("R4 high half kept", n, 20);

    // R5: tuning word 1 via select
    spi_send(16'h2028, 16);
    spi_send(16'h8000, 16);
    spi_send(16'h8800, 16);
    spi_send(16'h2828, 16);
    settle();
    count_edges(n);
    check("R5 tuning word 1 selected", n, 40);

    // R10: divided MSB, then disabled
    spi_send(16'h2820, 16);
    settle();
    count_edges(n);
    check("R10 divided msb", n, 20);
    spi_send(16'h2800, 16);
    settle();
    count_edges(n);
    check("R10 sign disabled edges", n, 0);
    check("R10 sign disabled level", sign_out, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule